// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. The page size is 1 KiB and the table has two levels. A requester, normally a TLB miss path or a CPU, hands over a virtual address with a valid/ready handshake. The walker then reads the table through a read port toward memory and returns one response. The response carries either a physical frame number and the full physical address, or a fault flag with a code that says which check failed.

The virtual address is split, from the most significant bit down, into three fields:
- a 12-bit outer index,
- a 10-bit inner index,
- a 10-bit page offset.

The outer index selects a 32-bit word in the outer table. The outer table starts at a root base address and is bounded by a length given in entries. A valid outer word points to an inner table. The inner index then selects the word that holds the frame number. The walker has only one memory read outstanding at any time. It takes a new request only while it is idle.

Top module: `ptw_walker`

## Requirements
- R1: The virtual address splits as outer index = bits [31:20], inner index = bits [19:10] and offset = bits [9:0]. The first memory read goes to root_base + outer index × 4.
- R2: A table word has its valid flag in bit 0 and a 22-bit pointer in bits [31:10]. Bits [9:1] are ignored. The second read goes to {outer pointer, 10'b0} + inner index × 4.
- R3: If the outer index is greater than or equal to root_len (sampled when the request is accepted), the response is a fault with code 1 and no memory read is issued.
- R4: An outer word with bit 0 clear gives a fault with code 2 after exactly one memory read.
- R5: An inner word with bit 0 clear gives a fault with code 3 after exactly two memory reads.
- R6: A successful walk gives rsp_fault = 0, code 0, rsp_frame = inner word bits [31:10] and rsp_paddr = {rsp_frame, offset}. On any fault, rsp_fault = 1 and rsp_frame and rsp_paddr read zero.
- R7: At most one memory read is outstanding. mem_req_valid stays high, and mem_req_addr stays stable, until mem_req_ready is seen.
- R8: req_ready is high only while idle. It is low from the cycle after acceptance until the response has been taken.
- R9: rsp_valid and all response fields stay stable until rsp_ready. In the cycle after the response is taken, rsp_valid is low and req_ready is high.
- R10: After reset, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0.
- R11: root_base and root_len are sampled only when a request is accepted. Changing them during a walk has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_base | input | 32 | Byte address of the outer table |
| root_len | input | 13 | Number of outer-table entries |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_fault_code | output | 2 | 0 none, 1 length bound, 2 outer invalid, 3 inner invalid |
| rsp_frame | output | 22 | Physical frame number |
| rsp_paddr | output | 32 | Physical address |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Read data present, one cycle |
| mem_rsp_data | input | 32 | Table word read |

## Verification
The bench sweeps four table lengths, including zero and the full 4096 entries. At each length it aims outer indices at 0, at length−1, at length and at 4095. A comparison off by one would either fault at length−1 or read past the table at length, and the count of memory reads exposes the stray read. Address-dependent table contents give all three fault classes and successful walks, with varying memory latency and stalls on the read port. Wrong field slicing or scaling shows up as a wrong recorded read address. On selected walks the root registers are overwritten while the walk runs; a design that reads them live would translate from the wrong table. Response back-pressure exposes any output that moves before it is taken, and any early return to idle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int unsigned VA_W        = 32;
    localparam int unsigned OFF_W       = 10;
    localparam int unsigned IN_W        = 10;
    localparam int unsigned OUT_W       = VA_W - OFF_W - IN_W;
    localparam int unsigned PFN_W       = VA_W - OFF_W;
    localparam int unsigned LEN_W       = OUT_W + 1;
    localparam int unsigned ENTRY_BYTES = 4;
    localparam int unsigned ENTRY_SH    = $clog2(ENTRY_BYTES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_OUTER,
        ST_WT_OUTER,
        ST_RD_INNER,
        ST_WT_INNER,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_BOUND = 2'd1,
        FLT_OUTER = 2'd2,
        FLT_INNER = 2'd3
    } fault_e;

    typedef struct packed {
        logic [PFN_W-1:0]   ptr;
        logic [OFF_W-2:0]   ign;
        logic               valid;
    } tbl_word_t;

    typedef struct packed {
        logic [OUT_W-1:0]   outer;
        logic [IN_W-1:0]    inner;
        logic [OFF_W-1:0]   off;
    } vaddr_t;

    function automatic logic [VA_W-1:0] slot_addr(input logic [VA_W-1:0] base,
                                                  input logic [VA_W-1:0] idx);
        return base + (idx << ENTRY_SH);
    endfunction
endpackage

// File: rtl/ptw_index_unit.sv
module ptw_index_unit
    import ptw_pkg::*;
(
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [LEN_W-1:0] req_len,
    input  vaddr_t           va_q,
    input  logic [VA_W-1:0]  root_q,
    input  logic [PFN_W-1:0] tbl_q,
    output logic             bound_fail,
    output logic [VA_W-1:0]  outer_addr,
    output logic [VA_W-1:0]  inner_addr
);
    vaddr_t           req_va;
    logic [VA_W-1:0]  inner_base;

    assign req_va     = vaddr_t'(req_vaddr);
    assign bound_fail = ({1'b0, req_va.outer} >= req_len);
    assign inner_base = {tbl_q, {OFF_W{1'b0}}};
    assign outer_addr = slot_addr(root_q, VA_W'(va_q.outer));
    assign inner_addr = slot_addr(inner_base, VA_W'(va_q.inner));
endmodule

// File: rtl/ptw_word_decode.sv
module ptw_word_decode
    import ptw_pkg::*;
(
    input  logic [VA_W-1:0]  word,
    output logic             valid,
    output logic [PFN_W-1:0] ptr
);
    tbl_word_t w;
    assign w     = tbl_word_t'(word);
    assign valid = w.valid;
    assign ptr   = w.ptr;
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        bound_fail,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    input  logic        word_valid,
    input  logic        rsp_ready,
    output walk_state_e state,
    output fault_e      code,
    output logic        cap_req,
    output logic        cap_outer,
    output logic        cap_inner
);
    assign cap_req   = (state == ST_IDLE) && req_valid;
    assign cap_outer = (state == ST_WT_OUTER) && mem_rsp_valid;
    assign cap_inner = (state == ST_WT_INNER) && mem_rsp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            code  <= FLT_NONE;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    if (bound_fail) begin
                        state <= ST_DONE;
                        code  <= FLT_BOUND;
                    end else begin
                        state <= ST_RD_OUTER;
                        code  <= FLT_NONE;
                    end
                end
                ST_RD_OUTER: if (mem_req_ready) state <= ST_WT_OUTER;
                ST_WT_OUTER: if (mem_rsp_valid) begin
                    if (!word_valid) begin
                        state <= ST_DONE;
                        code  <= FLT_OUTER;
                    end else begin
                        state <= ST_RD_INNER;
                    end
                end
                ST_RD_INNER: if (mem_req_ready) state <= ST_WT_INNER;
                ST_WT_INNER: if (mem_rsp_valid) begin
                    state <= ST_DONE;
                    if (!word_valid) code <= FLT_INNER;
                end
                ST_DONE: if (rsp_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [VA_W-1:0]    root_base,
    input  logic [LEN_W-1:0]   root_len,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic               rsp_fault,
    output logic [1:0]         rsp_fault_code,
    output logic [PFN_W-1:0]   rsp_frame,
    output logic [VA_W-1:0]    rsp_paddr,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [VA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [VA_W-1:0]    mem_rsp_data
);
    walk_state_e      state;
    fault_e           code;
    logic             cap_req, cap_outer, cap_inner;
    logic             bound_fail, word_valid;
    logic [PFN_W-1:0] word_ptr;
    logic [VA_W-1:0]  outer_addr, inner_addr;
    vaddr_t           va_q;
    logic [VA_W-1:0]  root_q;
    logic [PFN_W-1:0] tbl_q, pfn_q;
    logic             ok;

    ptw_index_unit idx_i (
        .req_vaddr  (req_vaddr),
        .req_len    (root_len),
        .va_q       (va_q),
        .root_q     (root_q),
        .tbl_q      (tbl_q),
        .bound_fail (bound_fail),
        .outer_addr (outer_addr),
        .inner_addr (inner_addr)
    );

    ptw_word_decode dec_i (
        .word  (mem_rsp_data),
        .valid (word_valid),
        .ptr   (word_ptr)
    );

    ptw_ctrl ctrl_i (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .bound_fail    (bound_fail),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .word_valid    (word_valid),
        .rsp_ready     (rsp_ready),
        .state         (state),
        .code          (code),
        .cap_req       (cap_req),
        .cap_outer     (cap_outer),
        .cap_inner     (cap_inner)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q   <= '0;
            root_q <= '0;
            tbl_q  <= '0;
            pfn_q  <= '0;
        end else begin
            if (cap_req) begin
                va_q   <= vaddr_t'(req_vaddr);
                root_q <= root_base;
                pfn_q  <= '0;
            end
            if (cap_outer) tbl_q <= word_ptr;
            if (cap_inner && word_valid) pfn_q <= word_ptr;
        end
    end

    assign ok             = (code == FLT_NONE);
    assign req_ready      = (state == ST_IDLE);
    assign rsp_valid      = (state == ST_DONE);
    assign rsp_fault      = !ok;
    assign rsp_fault_code = code;
    assign rsp_frame      = ok ? pfn_q : '0;
    assign rsp_paddr      = ok ? {pfn_q, va_q.off} : '0;
    assign mem_req_valid  = (state == ST_RD_OUTER) || (state == ST_RD_INNER);
    assign mem_req_addr   = (state == ST_RD_OUTER) ? outer_addr : inner_addr;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [1:0]  rsp_fault_code,
    input logic [31:0] rsp_paddr,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr
);
    assert_mem_hold_R7: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    assert_busy_no_accept_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid || rsp_valid) |-> !req_ready);

    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault_code));

    assert_idle_after_rsp_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_ready |=> req_ready && !rsp_valid);

    assert_one_channel_R7: assert property (@(posedge clk) disable iff (rst)
        !(mem_req_valid && rsp_valid));
endmodule

bind ptw_walker ptw_walker_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .req_ready      (req_ready),
    .rsp_valid      (rsp_valid),
    .rsp_ready      (rsp_ready),
    .rsp_fault_code (rsp_fault_code),
    .rsp_paddr      (rsp_paddr),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_addr   (mem_req_addr)
);

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] root_base = '0;
    logic [12:0] root_len = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic [1:0]  rsp_fault_code;
    logic [21:0] rsp_frame;
    logic [31:0] rsp_paddr;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int fails  = 0;
    int n_ok = 0, n_b = 0, n_o = 0, n_i = 0;

    always #2.5 clk = ~clk;

    ptw_walker dut_i (
        .clk(clk), .rst(rst), .root_base(root_base), .root_len(root_len),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
        .rsp_fault_code(rsp_fault_code), .rsp_frame(rsp_frame), .rsp_paddr(rsp_paddr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] h;
        h = a * 32'h9E3779B1;
        h = h ^ (h >> 15);
        return h;
    endfunction

    // memory model: stalls on request, latency from address bits
    int          hs_cnt = 0;
    logic [31:0] addr_log [4];
    logic [31:0] pend_addr = '0;
    logic        pend = 1'b0;
    logic [1:0]  lat = '0;
    int          cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rsp_valid <= 1'b0;
        mem_req_ready <= (cyc % 4) != 1;
        if (pend) begin
            if (lat == 2'd0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem_word(pend_addr);
                pend <= 1'b0;
            end else begin
                lat <= lat - 2'd1;
            end
        end else if (!rst && mem_req_valid && mem_req_ready) begin
            pend      <= 1'b1;
            lat       <= mem_req_addr[4:3];
            pend_addr <= mem_req_addr;
            addr_log[hs_cnt % 4] <= mem_req_addr;
            hs_cnt    <= hs_cnt + 1;
        end
    end

    task automatic check(input bit good, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 64'd0, 64'd1);
        summary();
    end

    task automatic walk(input logic [31:0] va, input logic [31:0] base,
                        input logic [12:0] len, input int hold, input bit perturb);
        int          hs0;
        int          waitc;
        logic [11:0] oi;
        logic [9:0]  ii;
        logic [31:0] a1, e1, a2, e2, exp_pa;
        logic [1:0]  exp_code;
        logic [21:0] exp_frame;
        int          exp_hs;
        logic [31:0] pa_s;
        logic [1:0]  code_s;

        oi = va[31:20];
        ii = va[19:10];
        a1 = base + {18'd0, oi, 2'b00};
        e1 = mem_word(a1);
        a2 = {e1[31:10], 10'd0} + {20'd0, ii, 2'b00};
        e2 = mem_word(a2);
        exp_frame = '0;
        exp_pa    = '0;
        if ({1'b0, oi} >= len)  begin exp_code = 2'd1; exp_hs = 0; n_b++; end  // R3
        else if (!e1[0])        begin exp_code = 2'd2; exp_hs = 1; n_o++; end  // R4
        else if (!e2[0])        begin exp_code = 2'd3; exp_hs = 2; n_i++; end  // R5
        else begin
            exp_code = 2'd0; exp_hs = 2; n_ok++;                              // R6
            exp_frame = e2[31:10];
            exp_pa = {e2[31:10], va[9:0]};
        end

        @(negedge clk);
        hs0 = hs_cnt;
        req_valid = 1'b1; req_vaddr = va; root_base = base; root_len = len;
        @(negedge clk);
        req_valid = 1'b0;
        if (perturb) begin  // R11: new root values must not affect this walk
            root_base = ~base;
            root_len  = 13'd0;
        end
        check(!req_ready, "R8 req_ready low while busy", {63'd0, req_ready}, 64'd0);
        waitc = 0;
        while (!rsp_valid && waitc < 300) begin
            @(negedge clk);
            waitc++;
        end
        pa_s = rsp_paddr;
        code_s = rsp_fault_code;
        for (int k = 0; k < hold; k++) @(negedge clk);
        check(rsp_valid && rsp_paddr == pa_s && rsp_fault_code == code_s,
              "R9 response held", {32'd0, rsp_paddr}, {32'd0, pa_s});
        check(rsp_fault_code == exp_code, "R3/R4/R5 fault code",
              {62'd0, rsp_fault_code}, {62'd0, exp_code});
        check(rsp_fault == (exp_code != 2'd0), "R6 fault flag",
              {63'd0, rsp_fault}, {63'd0, exp_code != 2'd0});
        check(rsp_frame == exp_frame, "R6 frame", {42'd0, rsp_frame}, {42'd0, exp_frame});
        check(rsp_paddr == exp_pa, "R6 R11 physical address", {32'd0, rsp_paddr}, {32'd0, exp_pa});
        check(hs_cnt - hs0 == exp_hs, "R7 read count",
              64'(hs_cnt - hs0), 64'(exp_hs));
        if (exp_hs >= 1)
            check(addr_log[hs0 % 4] == a1, "R1 outer read address",
                  {32'd0, addr_log[hs0 % 4]}, {32'd0, a1});
        if (exp_hs == 2)
            check(addr_log[(hs0 + 1) % 4] == a2, "R2 inner read address",
                  {32'd0, addr_log[(hs0 + 1) % 4]}, {32'd0, a2});
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(!rsp_valid && req_ready, "R9 idle after response",
              {62'd0, rsp_valid, req_ready}, 64'd1);
    endtask

    initial begin
        logic [12:0] lens [4];
        lens[0] = 13'd0; lens[1] = 13'd1; lens[2] = 13'd37; lens[3] = 13'd4096;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !rsp_valid && !mem_req_valid, "R10 reset state",
              {61'd0, req_ready, rsp_valid, mem_req_valid}, 64'd4);
        for (int l = 0; l < 4; l++) begin
            for (int j = 0; j < 48; j++) begin
                logic [11:0] oi;
                logic [9:0]  ii;
                logic [9:0]  off;
                case (j)
                    0: oi = 12'd0;
                    1: oi = 12'(lens[l] - 13'd1);
                    2: oi = 12'(lens[l]);
                    3: oi = 12'd4095;
                    default: oi = 12'((j * 97 + l * 13) % (lens[l] == 0 ? 4096 : int'(lens[l]) + 2));
                endcase
                ii  = 10'((j * 131 + l * 7) % 1024);
                off = 10'((j * 29 + 3) % 1024);
                walk({oi, ii, off}, 32'h0001_0000 + 32'(l * 4096 + j * 8), lens[l],
                     j % 3, (j % 5) == 4);
            end
        end
        check(n_ok > 0 && n_b > 0 && n_o > 0 && n_i > 0, "R3 R4 R5 R6 outcome coverage",
              64'(n_ok), 64'd1);
        summary();
    end
endmodule